// File: doc/BRIEF.md
# Programmable Logic Macrocell with Three-State I/O Cell

This block is one configurable logic cell of a programmable-logic fabric, paired with its pin driver. It receives an already-summed product-term value and a set of static configuration inputs. From these it produces the cell's logic value, which is either passed straight through, stored in an edge-triggered element, or held in a level-sensitive latch. One polarity control can invert the value sent to the pad. The storage element can load its data input or toggle on it. It is timed by one of several shared clock/gate lines, and it obeys two block-wide product terms that force it to 0 or to 1.

A capture option swaps the data source from the sum input to the pin itself. This lets a cell whose driver is unused sample or latch an incoming signal. The pad driver's enable comes from a small selector: never, always, or one of the block-shared enable terms. The block returns two feedback values. One is the cell's own value, before the polarity control. The other is the level actually present on the pin, so the pin can serve as an input while the driver is off.

All storage runs on a core clock `clk`. The clock/gate lines are sampled on that clock. A rising edge of a gate line is a core clock edge where the line is 1 and was 0 at the previous core edge. Latch transparency is judged from the level of the line at a core clock edge.

Top module: `mc_macrocell`

## Requirements
- R1: With `cfg_mode` 0 or 3 (pass-through), `fb_core` equals the data source in the same cycle. The data source is `sum_in`, or `pad_in` when `cfg_capture` is 1.
- R2: `pad_out` equals `fb_core` when `cfg_invert` is 0 and equals its complement when `cfg_invert` is 1. `fb_core` itself does not depend on `cfg_invert`.
- R3: With `cfg_mode` 1 (edge mode) and `cfg_ttype` 0, the state loads the data source at a rising edge of the selected gate line. It is unchanged at any other core clock edge, even while the line stays high.
- R4: With `cfg_mode` 1, `cfg_ttype` 1 and `cfg_capture` 0, the state inverts at a rising edge when `sum_in` is 1 and keeps its value when `sum_in` is 0.
- R5: `cfg_gsel` picks which bit of `gate_in` times the cell. Edges and levels on the other bits have no effect.
- R6: With `cfg_mode` 2 (latch), the state takes the data source at every core clock edge where the selected line is 0. It holds at every core clock edge where the line is 1.
- R7: When `ar_term` is 1, the state is 0 after the next core clock edge. When `ap_term` is 1 and `ar_term` is 0, the state is 1. This holds in every mode and at any gate activity. When both are 1, the result is 0.
- R8: While `rst_n` is 0, the state and the gate edge history are 0 at once. `fb_core` reads 0 in edge or latch mode.
- R9: The `cfg_oe` encoding is 0 = driver off, 1 = driver on, 2 = follow `oe_term[0]`, 3 = follow `oe_term[1]`. `pad_oe` reflects the selected source in the same cycle.
- R10: `fb_pin` equals `pad_out` while `pad_oe` is 1 and equals `pad_in` while `pad_oe` is 0.
- R11: With `cfg_capture` 1, storage loads `pad_in` and ignores `sum_in`. It also loads rather than toggles when `cfg_ttype` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous initialisation |
| sum_in | input | 1 | Summed product-term value |
| pad_in | input | 1 | Level seen on the pin |
| gate_in | input | NUM_GATES (2) | Shared clock/gate lines |
| ar_term | input | 1 | Block-wide force-to-0 term |
| ap_term | input | 1 | Block-wide force-to-1 term |
| oe_term | input | NUM_OE_TERMS (2) | Block-wide driver-enable terms |
| cfg_mode | input | 2 | 0/3 pass-through, 1 edge storage, 2 latch |
| cfg_ttype | input | 1 | 1 = toggle storage in edge mode |
| cfg_invert | input | 1 | 1 = invert the pad value |
| cfg_capture | input | 1 | 1 = data source is the pin |
| cfg_gsel | input | GSEL_W (1) | Selected gate line |
| cfg_oe | input | OESEL_W (2) | Driver-enable source |
| fb_core | output | 1 | Internal feedback of the cell value |
| pad_out | output | 1 | Value driven to the pin |
| pad_oe | output | 1 | Pin driver enable |
| fb_pin | output | 1 | Pin-level feedback |

## Verification
The assertions assume that `rst_n` is low from time zero. They assume the configuration inputs change only between core clock edges, and that every input is a known 0 or 1. They also assume that `pad_in` is the external level used for capture even while the driver is on. The bench sets all inputs to 0 before the first edge. It changes configuration and data only at falling edges of the core clock. It keeps every gate line high or low for at least one full core clock period, so each edge it means to create is seen exactly once.

// File: rtl/mc_pkg.sv
package mc_pkg;

  typedef enum logic [1:0] {
    MODE_PASS  = 2'd0,
    MODE_EDGE  = 2'd1,
    MODE_LATCH = 2'd2,
    MODE_PASS2 = 2'd3
  } mc_mode_e;

  // Next value of the storage element, before the forcing terms apply.
  function automatic logic store_next(input mc_mode_e mode,
                                      input logic     ttype,
                                      input logic     capture,
                                      input logic     cur,
                                      input logic     din,
                                      input logic     rise,
                                      input logic     lvl);
    logic nxt;
    nxt = cur;
    case (mode)
      MODE_EDGE:  if (rise) nxt = (ttype && !capture) ? (cur ^ din) : din;
      MODE_LATCH: if (!lvl) nxt = din;
      default:    nxt = cur;
    endcase
    return nxt;
  endfunction

  // Forcing terms: the zero term outranks the one term.
  function automatic logic apply_force(input logic nxt, input logic f0, input logic f1);
    logic r;
    r = nxt;
    if (f1) r = 1'b1;
    if (f0) r = 1'b0;
    return r;
  endfunction

  function automatic logic polarity(input logic val, input logic inv);
    return val ^ inv;
  endfunction

  function automatic logic is_pass(input mc_mode_e mode);
    return (mode == MODE_PASS) || (mode == MODE_PASS2);
  endfunction

endpackage

// File: rtl/mc_gate_sense.sv
module mc_gate_sense (
  input  logic clk,
  input  logic rst_n,
  input  logic gate_in,
  output logic gate_lvl,
  output logic gate_rise
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= gate_in;
  end

  assign gate_lvl  = gate_in;
  assign gate_rise = gate_in & ~prev_q;
endmodule

// File: rtl/mc_store.sv
module mc_store
  import mc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  mc_mode_e mode,
  input  logic     ttype,
  input  logic     capture,
  input  logic     din,
  input  logic     rise,
  input  logic     lvl,
  input  logic     force0,
  input  logic     force1,
  output logic     st_q
);
  logic nxt;

  always_comb begin
    nxt = store_next(mode, ttype, capture, st_q, din, rise, lvl);
    nxt = apply_force(nxt, force0, force1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= 1'b0;
    else        st_q <= nxt;
  end
endmodule

// File: rtl/mc_io_cell.sv
module mc_io_cell
  import mc_pkg::*;
#(
  parameter int NUM_OE_TERMS = 2,
  localparam int OESEL_W = $clog2(NUM_OE_TERMS + 2)
) (
  input  logic                    cell_val,
  input  logic                    invert,
  input  logic [OESEL_W-1:0]      oe_sel,
  input  logic [NUM_OE_TERMS-1:0] oe_term,
  input  logic                    pad_in,
  output logic                    pad_out,
  output logic                    pad_oe,
  output logic                    fb_pin
);
  logic en;

  always_comb begin
    en = 1'b0;
    if (oe_sel == OESEL_W'(1)) en = 1'b1;
    for (int k = 0; k < NUM_OE_TERMS; k++) begin
      if (oe_sel == OESEL_W'(k + 2)) en = oe_term[k];
    end
  end

  assign pad_out = polarity(cell_val, invert);
  assign pad_oe  = en;
  assign fb_pin  = en ? pad_out : pad_in;
endmodule

// File: rtl/mc_macrocell.sv
module mc_macrocell
  import mc_pkg::*;
#(
  parameter int NUM_GATES    = 2,
  parameter int NUM_OE_TERMS = 2,
  localparam int GSEL_W  = (NUM_GATES > 1) ? $clog2(NUM_GATES) : 1,
  localparam int OESEL_W = $clog2(NUM_OE_TERMS + 2)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sum_in,
  input  logic                    pad_in,
  input  logic [NUM_GATES-1:0]    gate_in,
  input  logic                    ar_term,
  input  logic                    ap_term,
  input  logic [NUM_OE_TERMS-1:0] oe_term,
  input  logic [1:0]              cfg_mode,
  input  logic                    cfg_ttype,
  input  logic                    cfg_invert,
  input  logic                    cfg_capture,
  input  logic [GSEL_W-1:0]       cfg_gsel,
  input  logic [OESEL_W-1:0]      cfg_oe,
  output logic                    fb_core,
  output logic                    pad_out,
  output logic                    pad_oe,
  output logic                    fb_pin
);
  mc_mode_e             mode_e;
  logic [NUM_GATES-1:0] gate_lvl;
  logic [NUM_GATES-1:0] gate_rise;
  logic                 sel_lvl;
  logic                 sel_rise;
  logic                 data_src;
  logic                 st_q;

  assign mode_e = mc_mode_e'(cfg_mode);

  for (genvar g = 0; g < NUM_GATES; g++) begin : g_sense
    mc_gate_sense u_sense (
      .clk      (clk),
      .rst_n    (rst_n),
      .gate_in  (gate_in[g]),
      .gate_lvl (gate_lvl[g]),
      .gate_rise(gate_rise[g])
    );
  end

  assign sel_lvl  = gate_lvl[cfg_gsel];
  assign sel_rise = gate_rise[cfg_gsel];
  assign data_src = cfg_capture ? pad_in : sum_in;

  mc_store u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode   (mode_e),
    .ttype  (cfg_ttype),
    .capture(cfg_capture),
    .din    (data_src),
    .rise   (sel_rise),
    .lvl    (sel_lvl),
    .force0 (ar_term),
    .force1 (ap_term),
    .st_q   (st_q)
  );

  assign fb_core = is_pass(mode_e) ? data_src : st_q;

  mc_io_cell #(.NUM_OE_TERMS(NUM_OE_TERMS)) u_io (
    .cell_val(fb_core),
    .invert  (cfg_invert),
    .oe_sel  (cfg_oe),
    .oe_term (oe_term),
    .pad_in  (pad_in),
    .pad_out (pad_out),
    .pad_oe  (pad_oe),
    .fb_pin  (fb_pin)
  );
endmodule

// File: rtl/mc_macrocell_chk.sv
module mc_macrocell_chk #(
  parameter int OESEL_W = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               sum_in,
  input logic               pad_in,
  input logic               ar_term,
  input logic               ap_term,
  input logic [1:0]         cfg_mode,
  input logic               cfg_ttype,
  input logic               cfg_capture,
  input logic [OESEL_W-1:0] cfg_oe,
  input logic               fb_core,
  input logic               pad_out,
  input logic               pad_oe,
  input logic               fb_pin,
  input logic               st_q,
  input logic               sel_rise,
  input logic               sel_lvl
);
  logic no_force;
  assign no_force = !ar_term && !ap_term;

  a_r1_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == 2'd0 && !cfg_capture) |-> (fb_core == sum_in));

  a_r3_load_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == 2'd1 && !cfg_ttype && !cfg_capture && sel_rise && no_force)
      |=> (st_q == $past(sum_in)));

  a_r3_hold_without_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == 2'd1 && !sel_rise && no_force) |=> $stable(st_q));

  a_r4_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == 2'd1 && cfg_ttype && !cfg_capture && sel_rise && no_force)
      |=> (st_q == ($past(st_q) ^ $past(sum_in))));

  a_r6_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == 2'd2 && sel_lvl && no_force) |=> $stable(st_q));

  a_r6_latch_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == 2'd2 && !sel_lvl && !cfg_capture && no_force)
      |=> (st_q == $past(sum_in)));

  a_r7_zero_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ar_term |=> !st_q);

  a_r7_force_one: assert property (@(posedge clk) disable iff (!rst_n)
    (ap_term && !ar_term) |=> st_q);

  a_r9_driver_off: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_oe == OESEL_W'(0)) |-> !pad_oe);

  a_r9_driver_on: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_oe == OESEL_W'(1)) |-> pad_oe);

  a_r10_pin_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !pad_oe |-> (fb_pin == pad_in));

  a_r10_pin_when_on: assert property (@(posedge clk) disable iff (!rst_n)
    pad_oe |-> (fb_pin == pad_out));

  a_r11_capture_load: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == 2'd1 && cfg_capture && sel_rise && no_force)
      |=> (st_q == $past(pad_in)));
endmodule

bind mc_macrocell mc_macrocell_chk #(.OESEL_W(OESEL_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sum_in     (sum_in),
  .pad_in     (pad_in),
  .ar_term    (ar_term),
  .ap_term    (ap_term),
  .cfg_mode   (cfg_mode),
  .cfg_ttype  (cfg_ttype),
  .cfg_capture(cfg_capture),
  .cfg_oe     (cfg_oe),
  .fb_core    (fb_core),
  .pad_out    (pad_out),
  .pad_oe     (pad_oe),
  .fb_pin     (fb_pin),
  .st_q       (st_q),
  .sel_rise   (sel_rise),
  .sel_lvl    (sel_lvl)
);

// File: tb/test_mc_macrocell.sv
module test_mc_macrocell;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 200000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       sum_in, pad_in, ar_term, ap_term;
  logic [1:0] gate_in;
  logic [1:0] oe_term;
  logic [1:0] cfg_mode;
  logic       cfg_ttype, cfg_invert, cfg_capture;
  logic [0:0] cfg_gsel;
  logic [1:0] cfg_oe;
  logic       fb_core, pad_out, pad_oe, fb_pin;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mc_macrocell i_mc_macrocell (
    .clk(clk), .rst_n(rst_n), .sum_in(sum_in), .pad_in(pad_in),
    .gate_in(gate_in), .ar_term(ar_term), .ap_term(ap_term), .oe_term(oe_term),
    .cfg_mode(cfg_mode), .cfg_ttype(cfg_ttype), .cfg_invert(cfg_invert),
    .cfg_capture(cfg_capture), .cfg_gsel(cfg_gsel), .cfg_oe(cfg_oe),
    .fb_core(fb_core), .pad_out(pad_out), .pad_oe(pad_oe), .fb_pin(fb_pin)
  );

  // Pass-through vectors:
  // {capture, invert, oe[1:0], oe_term[1:0], sum, pin | fb_core, pad_out, pad_oe, fb_pin}
  localparam logic [11:0] VEC [9] = '{
    12'b0_0_01_00_1_0_1_1_1_1,  // R1 R9 driver on
    12'b0_1_01_00_1_0_1_0_1_0,  // R2 inverted
    12'b0_0_00_11_1_0_1_1_0_0,  // R9 off ignores terms
    12'b0_0_10_01_0_1_0_0_1_0,  // R9 term0 = 1, R10 driven
    12'b0_0_10_10_0_1_0_0_0_1,  // R9 term0 = 0, R10 pin
    12'b0_1_11_10_0_0_0_1_1_1,  // R9 term1 = 1
    12'b0_0_11_01_1_0_1_1_0_0,  // R9 term1 = 0
    12'b1_0_00_00_0_1_1_1_0_1,  // R11 pin as source
    12'b1_1_00_00_1_0_0_1_0_0   // R11 sum ignored, R2
  };

  task automatic check(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic pulse(input int idx);
    @(negedge clk) gate_in[idx] = 1'b1;
    @(negedge clk) gate_in[idx] = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG_CYCLES);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sum_in = 1'b0; pad_in = 1'b0; ar_term = 1'b0; ap_term = 1'b0;
    gate_in = '0; oe_term = '0; cfg_mode = 2'd1; cfg_ttype = 1'b0;
    cfg_invert = 1'b0; cfg_capture = 1'b0; cfg_gsel = '0; cfg_oe = 2'd0;

    // R8: initialisation state
    repeat (3) tick();
    check("R8 reset state", fb_core, 1'b0);
    check("R9 reset driver off", pad_oe, 1'b0);
    rst_n = 1'b1;
    tick();
    check("R8 after release", fb_core, 1'b0);

    // R1 R2 R9 R10 R11: pass-through table
    cfg_mode = 2'd0;
    for (int i = 0; i < 9; i++) begin
      logic [11:0] v;
      v = VEC[i];
      cfg_capture = v[11]; cfg_invert = v[10]; cfg_oe = v[9:8];
      oe_term = v[7:6]; sum_in = v[5]; pad_in = v[4];
      #1;
      check("R1 fb_core", fb_core, v[3]);
      check("R2 pad_out", pad_out, v[2]);
      check("R9 pad_oe", pad_oe, v[1]);
      check("R10 fb_pin", fb_pin, v[0]);
      tick();
    end
    cfg_capture = 1'b0; cfg_invert = 1'b0; cfg_oe = 2'd0; oe_term = '0;
    pad_in = 1'b0;

    // R3: edge-triggered load
    cfg_mode = 2'd1; cfg_ttype = 1'b0; cfg_gsel = 1'b0;
    sum_in = 1'b1;
    pulse(0);
    check("R3 load 1", fb_core, 1'b1);
    sum_in = 1'b0;
    tick(); tick();
    check("R3 hold without edge", fb_core, 1'b1);
    gate_in[0] = 1'b1;
    tick();
    check("R3 load 0", fb_core, 1'b0);
    sum_in = 1'b1;
    tick();
    check("R3 high level no reload", fb_core, 1'b0);
    gate_in[0] = 1'b0;
    tick();

    // R5: gate selection
    pulse(1);
    check("R5 unselected line ignored", fb_core, 1'b0);
    cfg_gsel = 1'b1;
    pulse(1);
    check("R5 line b selected", fb_core, 1'b1);
    sum_in = 1'b0;
    pulse(0);
    check("R5 line a ignored", fb_core, 1'b1);
    cfg_gsel = 1'b0;

    // R4: toggle storage
    cfg_ttype = 1'b1; sum_in = 1'b1;
    pulse(0);
    check("R4 toggle to 0", fb_core, 1'b0);
    pulse(0);
    check("R4 toggle to 1", fb_core, 1'b1);
    sum_in = 1'b0;
    pulse(0);
    check("R4 hold on 0", fb_core, 1'b1);

    // R11: capture loads the pin even in toggle mode
    cfg_capture = 1'b1; sum_in = 1'b1; pad_in = 1'b1;
    pulse(0);
    check("R11 capture pin 1", fb_core, 1'b1);
    pad_in = 1'b0;
    pulse(0);
    check("R11 capture pin 0", fb_core, 1'b0);
    cfg_capture = 1'b0; cfg_ttype = 1'b0;

    // R2: polarity on a stored value
    cfg_invert = 1'b1;
    #1;
    check("R2 inverted stored", pad_out, 1'b1);
    check("R2 fb_core unaffected", fb_core, 1'b0);
    cfg_invert = 1'b0;

    // R6: latch
    cfg_mode = 2'd2; sum_in = 1'b1;
    tick();
    check("R6 transparent 1", fb_core, 1'b1);
    sum_in = 1'b0;
    tick();
    check("R6 transparent 0", fb_core, 1'b0);
    gate_in[0] = 1'b1; sum_in = 1'b1;
    tick();
    check("R6 hold at gate high", fb_core, 1'b0);
    tick();
    check("R6 still holding", fb_core, 1'b0);
    gate_in[0] = 1'b0;
    tick();
    check("R6 reopened", fb_core, 1'b1);

    // R7: forcing terms, latch mode open with data 1
    ar_term = 1'b1;
    tick();
    check("R7 zero in latch", fb_core, 1'b0);
    ar_term = 1'b0;
    tick();
    check("R7 released latch", fb_core, 1'b1);
    cfg_mode = 2'd1; sum_in = 1'b0;
    ar_term = 1'b1;
    tick();
    check("R7 zero in edge mode", fb_core, 1'b0);
    ar_term = 1'b0; ap_term = 1'b1;
    tick();
    check("R7 one in edge mode", fb_core, 1'b1);
    ar_term = 1'b1;
    tick();
    check("R7 both gives 0", fb_core, 1'b0);
    ar_term = 1'b0;
    tick();
    check("R7 one alone again", fb_core, 1'b1);
    ap_term = 1'b0;
    tick();
    check("R7 held after release", fb_core, 1'b1);

    // R8: initialisation in mid-run
    rst_n = 1'b0;
    #1;
    check("R8 immediate clear", fb_core, 1'b0);
    tick();
    rst_n = 1'b1;
    tick();
    check("R8 stays 0", fb_core, 1'b0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule